// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word-address stream for a synchronous burst read from a memory array that is 16 bits wide. A configuration word is captured from a 16-bit bus field when a write strobe is seen. It sets whether bursts are enabled, the first-access latency in clock cycles, the burst length (4, 8 or continuous), the ordering inside a group (sequential or interleaved) and whether the burst wraps inside its aligned group or runs on linearly.

When a start request arrives in synchronous mode, the block waits out the programmed latency. It then presents one word address per clock with a valid strobe. In linear bursts it holds one WAIT cycle, with no valid word, before any word that begins a new 16-word group. A stop input ends a burst early, and it is the only way a continuous burst ends. The configuration in force at the start request governs that burst to its end.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the configuration has the async bit set, so no burst runs. While the async bit is 1, start requests produce no valid word and no WAIT.
- R2: A pulse on cfg_wr loads cfg_bus, with bit n taken from line n. The fields are: [15] async (1 disables bursts), [14:11] latency L, [7] interleave (1 = interleaved), [3] no-wrap (1 = linear), [2:0] length code (001 = 4 words, 010 = 8 words, 111 = continuous, any other code = 4 words).
- R3: Call the cycle in which burst_start is sampled cycle 0. The first word (or WAIT) appears in cycle L. L values of 0 and 1 both behave as 1.
- R4: A wrapped sequential burst of N words (N = 4 or 8) starting at in-group offset s gives beat i the address of the aligned group with offset (s+i) mod N. For example, 7-0-1-2-3-4-5-6 for N = 8 and s = 7.
- R5: A wrapped interleaved burst gives beat i the group offset s XOR i. For example, 1-0-3-2 for N = 4 and s = 1.
- R6: A linear burst gives word i the address start+i. In linear mode the interleave bit has no effect.
- R7: In a linear burst, every word whose address has its low 4 bits at zero is preceded by exactly one cycle with wait_out = 1 and word_valid = 0. The first word of a burst is the exception and gets no WAIT.
- R8: A fixed-length burst presents exactly N valid words. word_valid then stays low until the next start.
- R9: A continuous burst always runs linearly and keeps presenting words until burst_stop. A burst_stop sampled at an edge ends any burst, including one still in its latency phase. The word shown in the cycle where stop is high still counts.
- R10: A start request during a burst is ignored. A configuration write during a burst takes effect only at the next start.
- R11: word_valid and wait_out are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration capture strobe |
| cfg_bus | input | 16 | Configuration value, taken from address lines 15..0 |
| burst_start | input | 1 | Start request, sampled in idle |
| start_addr | input | AW (21) | Word address of the first beat |
| burst_stop | input | 1 | Ends the current burst after this cycle |
| word_addr | output | AW (21) | Current word address |
| word_valid | output | 1 | word_addr holds a burst word this cycle |
| wait_out | output | 1 | Boundary WAIT cycle of a linear burst |

## Verification
The assertions assume that burst_stop is never raised in a WAIT cycle. Under that assumption, every WAIT is followed by a word on a 16-word boundary. They also take the start address to be stable only at the start edge, with no constraint on it afterwards. The stimulus raises stop only on the final expected word of a continuous burst and never during a WAIT. It scrambles start_addr after each start, and it changes the configuration only between bursts, apart from the deliberate write made in the middle of a burst for R10. Random bursts draw every field, including the unlisted length codes, the extreme latencies and start offsets near group and boundary edges.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int CFG_W = 16;
    localparam int LAT_W = 4;
    localparam int G4_W  = 2;
    localparam int G8_W  = 3;

    localparam logic [2:0] LEN_CODE_8    = 3'b010;
    localparam logic [2:0] LEN_CODE_CONT = 3'b111;

    // async set, latency 4, length code 4 words
    localparam logic [CFG_W-1:0] CFG_RESET = 16'hA001;

    typedef enum logic [1:0] {
        BLEN_4    = 2'd0,
        BLEN_8    = 2'd1,
        BLEN_CONT = 2'd2
    } blen_e;

    typedef struct packed {
        logic             async_mode;
        logic [LAT_W-1:0] latency;
        logic             interleave;
        logic             no_wrap;
        blen_e            len;
    } bcfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_RUN  = 2'd2
    } bstate_e;

    function automatic bcfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        bcfg_t c;
        c.async_mode = raw[15];
        c.latency    = raw[14:11];
        c.interleave = raw[7];
        c.no_wrap    = raw[3];
        case (raw[2:0])
            LEN_CODE_8:    c.len = BLEN_8;
            LEN_CODE_CONT: c.len = BLEN_CONT;
            default:       c.len = BLEN_4;
        endcase
        return c;
    endfunction

    function automatic logic is_linear(input bcfg_t c);
        return c.no_wrap || (c.len == BLEN_CONT);
    endfunction

endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
    import bseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_bus,
    output bcfg_t            cfg
);

    logic [CFG_W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= CFG_RESET;
        else if (cfg_wr)
            raw_q <= cfg_bus;
    end

    assign cfg = decode_cfg(raw_q);

endmodule

// File: rtl/bseq_lat_timer.sv
module bseq_lat_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    input  logic             abort,
    output logic             expire
);

    logic [LAT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= lat - LAT_W'(2);
        end else if (abort) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    assign expire = run_q && (cnt_q == '0);

endmodule

// File: rtl/bseq_addr_calc.sv
module bseq_addr_calc
    import bseq_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   lin,
    input  logic [G8_W-1:0] beat,
    input  bcfg_t           cfg,
    output logic [AW-1:0]   addr
);

    logic [G8_W-1:0] off8;
    logic [G4_W-1:0] off4;

    always_comb begin
        off8 = cfg.interleave ? (base[G8_W-1:0] ^ beat)
                              : (base[G8_W-1:0] + beat);
        off4 = cfg.interleave ? (base[G4_W-1:0] ^ beat[G4_W-1:0])
                              : (base[G4_W-1:0] + beat[G4_W-1:0]);
        addr = lin;
        if (!is_linear(cfg)) begin
            if (cfg.len == BLEN_8)
                addr = {base[AW-1:G8_W], off8};
            else
                addr = {base[AW-1:G4_W], off4};
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int AW         = 21,
    parameter int BOUND_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_bus,
    input  logic             burst_start,
    input  logic [AW-1:0]    start_addr,
    input  logic             burst_stop,
    output logic [AW-1:0]    word_addr,
    output logic             word_valid,
    output logic             wait_out
);

    localparam logic [G8_W-1:0] LAST_BEAT8 = G8_W'((1 << G8_W) - 1);
    localparam logic [G8_W-1:0] LAST_BEAT4 = G8_W'((1 << G4_W) - 1);

    bcfg_t           cfg;
    bcfg_t           snap_q;
    bstate_e         state_q;
    logic [AW-1:0]   base_q;
    logic [AW-1:0]   lin_q;
    logic [G8_W-1:0] beat_q;
    logic            first_q;
    logic            waited_q;

    logic start_ok;
    logic lat_short;
    logic lat_expire;
    logic wait_now;
    logic last_beat;

    bseq_cfg_reg cfg_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_bus (cfg_bus),
        .cfg     (cfg)
    );

    assign start_ok  = (state_q == ST_IDLE) && burst_start && !cfg.async_mode;
    assign lat_short = (cfg.latency <= LAT_W'(1));

    bseq_lat_timer #(.LAT_W(LAT_W)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .load   (start_ok && !lat_short),
        .lat    (cfg.latency),
        .abort  (burst_stop),
        .expire (lat_expire)
    );

    bseq_addr_calc #(.AW(AW)) calc_i (
        .base (base_q),
        .lin  (lin_q),
        .beat (beat_q),
        .cfg  (snap_q),
        .addr (word_addr)
    );

    assign wait_now  = (state_q == ST_RUN) && is_linear(snap_q) && !first_q &&
                       !waited_q && (lin_q[BOUND_LOG2-1:0] == '0);
    assign last_beat = (snap_q.len == BLEN_8) ? (beat_q == LAST_BEAT8)
                                              : (beat_q == LAST_BEAT4);

    assign word_valid = (state_q == ST_RUN) && !wait_now;
    assign wait_out   = wait_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            snap_q   <= decode_cfg(CFG_RESET);
            base_q   <= '0;
            lin_q    <= '0;
            beat_q   <= '0;
            first_q  <= 1'b0;
            waited_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        snap_q   <= cfg;
                        base_q   <= start_addr;
                        lin_q    <= start_addr;
                        beat_q   <= '0;
                        first_q  <= 1'b1;
                        waited_q <= 1'b0;
                        state_q  <= lat_short ? ST_RUN : ST_LAT;
                    end
                end
                ST_LAT: begin
                    if (burst_stop)
                        state_q <= ST_IDLE;
                    else if (lat_expire)
                        state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (burst_stop) begin
                        state_q <= ST_IDLE;
                    end else if (wait_now) begin
                        waited_q <= 1'b1;
                    end else begin
                        lin_q    <= lin_q + AW'(1);
                        beat_q   <= beat_q + G8_W'(1);
                        first_q  <= 1'b0;
                        waited_q <= 1'b0;
                        if ((snap_q.len != BLEN_CONT) && last_beat)
                            state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int BOUND_LOG2 = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_wr,
    input logic                  cfg_async_bit,
    input logic                  burst_stop,
    input logic                  word_valid,
    input logic                  wait_out,
    input logic [BOUND_LOG2-1:0] addr_low
);

    logic sync_seen;

    always_ff @(posedge clk) begin
        if (rst)
            sync_seen <= 1'b0;
        else if (cfg_wr && !cfg_async_bit)
            sync_seen <= 1'b1;
    end

    assert_valid_wait_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(word_valid && wait_out));

    assert_wait_then_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (wait_out && !burst_stop) |=> (word_valid && (addr_low == '0)));

    assert_single_wait_R7: assert property (@(posedge clk) disable iff (rst)
        wait_out |=> !wait_out);

    assert_no_burst_async_R1: assert property (@(posedge clk) disable iff (rst)
        !sync_seen |-> (!word_valid && !wait_out));

    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (rst)
        (word_valid && burst_stop) |=> !word_valid);

endmodule

bind burst_addr_seq bseq_chk #(.BOUND_LOG2(BOUND_LOG2)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_async_bit (cfg_bus[15]),
    .burst_stop    (burst_stop),
    .word_valid    (word_valid),
    .wait_out      (wait_out),
    .addr_low      (word_addr[BOUND_LOG2-1:0])
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [15:0]   cfg_bus = '0;
    logic          burst_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          burst_stop = 1'b0;
    logic [AW-1:0] word_addr;
    logic          word_valid;
    logic          wait_out;

    int checks = 0;
    int failures = 0;

    logic [AW-1:0] ex_addr [64];
    logic          ex_wait [64];
    int            ex_n;

    always #4 clk = ~clk;

    burst_addr_seq #(.AW(AW), .BOUND_LOG2(4)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_bus     (cfg_bus),
        .burst_start (burst_start),
        .start_addr  (start_addr),
        .burst_stop  (burst_stop),
        .word_addr   (word_addr),
        .word_valid  (word_valid),
        .wait_out    (wait_out)
    );

    function automatic logic [15:0] mk_cfg(bit am, int lat, bit il, bit nw, logic [2:0] lc);
        logic [15:0] v;
        v = '0;
        v[15] = am;
        v[14:11] = lat[3:0];
        v[7] = il;
        v[3] = nw;
        v[2:0] = lc;
        return v;
    endfunction

    task automatic chk_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_addr(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build_expect(bit il, bit nw, logic [2:0] lc, logic [AW-1:0] sa, int cont_words);
        int nwords, gsz, words, s_off, off;
        bit linear, waited, first;
        logic [AW-1:0] lin;
        nwords = (lc == 3'b010) ? 8 : (lc == 3'b111) ? cont_words : 4;
        gsz    = (lc == 3'b010) ? 8 : 4;
        linear = nw || (lc == 3'b111);
        s_off  = int'(sa[2:0]) % gsz;
        ex_n = 0; lin = sa; first = 1; waited = 0; words = 0;
        while (words < nwords) begin
            if (linear && !first && !waited && lin[3:0] == 4'h0) begin
                ex_wait[ex_n] = 1'b1;
                ex_addr[ex_n] = '0;
                ex_n++;
                waited = 1;
            end else begin
                ex_wait[ex_n] = 1'b0;
                if (linear) begin
                    ex_addr[ex_n] = lin;
                end else begin
                    off = il ? (s_off ^ words) : ((s_off + words) % gsz);
                    ex_addr[ex_n] = (sa & ~AW'(gsz - 1)) | AW'(off);
                end
                ex_n++; lin++; words++; first = 0; waited = 0;
            end
        end
    endtask

    task automatic cfg_write(logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_bus = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Runs one burst with the configuration already written; poke exercises R10.
    task automatic run_burst(string tag, int lat, bit il, bit nw, logic [2:0] lc,
                             logic [AW-1:0] sa, int cont_words, bit poke);
        int leff, total;
        build_expect(il, nw, lc, sa, cont_words);
        leff = (lat <= 1) ? 1 : lat;
        @(negedge clk);
        burst_start = 1'b1;
        start_addr  = sa;
        @(negedge clk);
        burst_start = 1'b0;
        start_addr  = ~sa;
        total = leff - 1 + ex_n + 3;
        for (int k = 1; k <= total; k++) begin
            int e;
            e = k - leff;
            if (e < 0 || e >= ex_n) begin
                chk_bit({tag, " idle valid R3 R8"}, word_valid, 1'b0);
                chk_bit({tag, " idle wait R7"}, wait_out, 1'b0);
            end else begin
                chk_bit({tag, " valid R11"}, word_valid, !ex_wait[e]);
                chk_bit({tag, " wait R7"}, wait_out, ex_wait[e]);
                if (!ex_wait[e])
                    chk_addr({tag, " addr"}, word_addr, ex_addr[e]);
            end
            burst_stop = (lc == 3'b111 && e == ex_n - 1);
            if (poke && k == 2) begin
                burst_start = 1'b1;
                start_addr  = sa + AW'(5);
                cfg_wr      = 1'b1;
                cfg_bus     = mk_cfg(0, 2, !il, !nw, 3'b010);
            end else begin
                burst_start = 1'b0;
                cfg_wr      = 1'b0;
            end
            @(negedge clk);
        end
        burst_stop = 1'b0;
    endtask

    task automatic cfg_and_run(string tag, int lat, bit il, bit nw, logic [2:0] lc,
                               logic [AW-1:0] sa, int cont_words, bit poke);
        cfg_write(mk_cfg(0, lat, il, nw, lc));
        run_burst(tag, lat, il, nw, lc, sa, cont_words, poke);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_bit("reset valid R1", word_valid, 1'b0);
        chk_bit("reset wait R1", wait_out, 1'b0);

        // R1: reset configuration is async, start ignored
        @(negedge clk);
        burst_start = 1'b1; start_addr = 21'h100;
        @(negedge clk);
        burst_start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk_bit("async start valid R1", word_valid, 1'b0);
            chk_bit("async start wait R1", wait_out, 1'b0);
            @(negedge clk);
        end

        cfg_and_run("seq4 wrap s1 R4 R3", 4, 0, 0, 3'b001, 21'h101, 0, 0);
        cfg_and_run("ilv4 wrap s1 R5", 4, 1, 0, 3'b001, 21'h101, 0, 0);
        cfg_and_run("seq8 wrap s7 R4 R8", 3, 0, 0, 3'b010, 21'h207, 0, 0);
        cfg_and_run("ilv8 wrap s5 R5", 2, 1, 0, 3'b010, 21'h33D, 0, 0);
        cfg_and_run("lin4 s1 il ignored R6", 4, 1, 1, 3'b001, 21'h001, 0, 0);
        cfg_and_run("lin4 s13 boundary R7", 4, 0, 1, 3'b001, 21'h00D, 0, 0);
        cfg_and_run("lin8 start on boundary R7", 5, 0, 1, 3'b010, 21'h040, 0, 0);
        cfg_and_run("cont crossing R9 R7", 4, 0, 0, 3'b111, 21'h02E, 24, 0);
        cfg_and_run("lat0 R3", 0, 0, 0, 3'b001, 21'h012, 0, 0);
        cfg_and_run("lat1 R3", 1, 0, 1, 3'b010, 21'h01C, 0, 0);
        cfg_and_run("lat15 R3", 15, 1, 0, 3'b001, 21'h1FFFFF, 0, 0);
        cfg_and_run("reserved len code R2", 3, 0, 0, 3'b100, 21'h0A6, 0, 0);
        cfg_and_run("restart and cfg during burst R10", 6, 0, 0, 3'b010, 21'h123, 0, 1);

        // R9: stop during latency phase
        cfg_write(mk_cfg(0, 8, 0, 1, 3'b111));
        @(negedge clk);
        burst_start = 1'b1; start_addr = 21'h050;
        @(negedge clk);
        burst_start = 1'b0;
        @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        for (int k = 0; k < 14; k++) begin
            chk_bit("stop in latency valid R9", word_valid, 1'b0);
            @(negedge clk);
        end

        // R1/R2: async bit set again disables bursts
        cfg_write(mk_cfg(1, 2, 0, 0, 3'b001));
        @(negedge clk);
        burst_start = 1'b1; start_addr = 21'h300;
        @(negedge clk);
        burst_start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk_bit("async again valid R1", word_valid, 1'b0);
            @(negedge clk);
        end

        for (int it = 0; it < 60; it++) begin
            int lat, pick, cw;
            bit il, nw;
            logic [2:0] lc;
            logic [AW-1:0] sa;
            lat  = int'($urandom % 16);
            il   = 1'($urandom % 2);
            nw   = 1'($urandom % 2);
            pick = int'($urandom % 5);
            lc   = (pick == 0) ? 3'b001 : (pick == 1) ? 3'b010 : (pick == 2) ? 3'b111 :
                   (pick == 3) ? 3'b000 : 3'b101;
            sa   = AW'($urandom);
            if (($urandom % 3) == 0) sa[3:0] = 4'hD + 4'(($urandom % 3));
            cw   = 5 + int'($urandom % 36);
            cfg_and_run("random R4 R5 R6 R7 R8 R9", lat, il, nw, lc, sa, cw, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule